// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block is the master side of an external bus on which one set of wires carries first an address and then data. A requester hands it a start address, a direction, an instruction/data flag, a word count and, word by word, the write data. The controller then runs one bus cycle: a single address phase, followed by data beats that each finish when the target acknowledges. It drives the cycle-in-progress, data-enable, read, write and last-beat strobes, all active low, and also a direction level and an instruction flag.

The target port may be 8, 16 or 32 bits wide, chosen by a 2-bit width code. Each 32-bit word is split into one, two or four beats, and narrow beats use the low byte lanes of the bus. The four active-low lane outputs are byte enables on a full-width port. On narrow ports some of them carry the low address bits of the beat instead. A target may ask for a retry, which restarts the cycle from its address phase. The rules for retry differ between reads and writes. A bus error aborts the cycle and is reported to the requester.

Top module: `mbus_ctrl`

## Requirements
- R1: The width code is latched when a request is accepted: 2'b00 selects an 8-bit port (4 beats per word), 2'b01 a 16-bit port (2 beats), 2'b10 a 32-bit port (1 beat). Beat k of word w has byte address {start[31:2]+w, 2'b00} + k*(port bytes).
- R2: On a 32-bit port, lane_no is 4'b0000 for the whole cycle.
- R3: On a 16-bit port, lane_no[3] and lane_no[0] are low, lane_no[2] is high and lane_no[1] equals address bit 1 of the current beat.
- R4: On an 8-bit port, lane_no[3:2] are high and lane_no[1:0] equal address bits 1:0 of the current beat. Outside a cycle lane_no is 4'hF.
- R5: Width code 2'b11 behaves as a 32-bit port and sets cfg_err_o, which stays high until reset.
- R6: The address phase lasts one cycle. In it cip_no is low, den_no is high and ad_o is the start address with bits 1:0 cleared. In both phases dtr_o is 1 for writes and 0 for reads, exactly one of rd_no and wr_no is low, and ide_o carries the instruction flag.
- R7: In data beats den_no is low. cip_no stays low until the acknowledge of the final beat is sampled. On the next cycle every strobe is high and done_o pulses for one cycle.
- R8: last_no is low only in the final data beat of the transfer.
- R9: A write beat puts its part of word word_idx_o on the low lanes of ad_o, with the other bits zero. Read beats are taken from the low lanes of ad_i, lowest address first. The cycle after each word completes, rd_valid_o pulses with the whole word on rd_data_o.
- R10: On a read, retry_ni low restarts the cycle at its address phase only while no beat of this attempt has been acknowledged. After that, retry is ignored and a concurrent ack_ni completes the beat.
- R11: On a write, retry_ni low in any beat restarts from the address phase with the original address and word count, beginning again at word 0. It takes priority over a concurrent ack_ni.
- R12: berr_ni low in either phase ends the cycle. On the next cycle all strobes are high and err_o pulses. It takes priority over retry and acknowledge.
- R13: A request is accepted only while ready_o is high (idle). A request raised during a cycle is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| ready_o | output | 1 | Controller idle |
| req_addr_i | input | 32 | Start byte address (bits 1:0 ignored) |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_instr_i | input | 1 | Instruction (1) or data (0) transfer |
| req_len_i | input | LEN_W | Word count minus one |
| width_i | input | 2 | Port width code |
| wr_data_i | input | 32 | Write data for word word_idx_o |
| word_idx_o | output | LEN_W | Index of the word being transferred |
| rd_data_o | output | 32 | Assembled read word |
| rd_valid_o | output | 1 | rd_data_o valid pulse |
| done_o | output | 1 | Transfer completed pulse |
| err_o | output | 1 | Transfer aborted by bus error pulse |
| cfg_err_o | output | 1 | Sticky reserved-width flag |
| ad_o | output | 32 | Multiplexed address/data out |
| ad_i | input | 32 | Multiplexed data in |
| cip_no | output | 1 | Cycle in progress, active low |
| den_no | output | 1 | Data phase, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| dtr_o | output | 1 | Direction: 1 write, 0 read |
| ide_o | output | 1 | Instruction/data flag |
| last_no | output | 1 | Final beat, active low |
| lane_no | output | 4 | Lane enables / low address bits, active low |
| ack_ni | input | 1 | Beat acknowledge, active low |
| retry_ni | input | 1 | Retry request, active low |
| berr_ni | input | 1 | Bus error, active low |

## Verification
Two functions can hit the same beat: retry with acknowledge, and bus error with acknowledge or retry. The bench provokes this by driving retry_ni and ack_ni low on the same edge. On a write it expects a fresh address phase at word 0. On a read where a beat has already been acknowledged, it expects the beat to complete and the cycle to go on. Bus errors are always injected together with an acknowledge, and the cycle must end with err_o and no done_o. Random transfers over all widths and lengths add wait states and lone retries in read waits, and each beat's lanes, data and last flag are compared with values the bench computes.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int AD_W   = 32;
  localparam int LANES  = AD_W / 8;
  localparam int BEAT_W = $clog2(LANES);

  typedef enum logic [1:0] {
    PW8   = 2'b00,
    PW16  = 2'b01,
    PW32  = 2'b10,
    PWRSV = 2'b11
  } pw_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_DATA = 2'b10
  } st_e;
endpackage

// File: rtl/mbus_beat_ctr.sv
module mbus_beat_ctr
  import mbus_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  pw_e               pw_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic [LEN_W-1:0]  word_o,
  output logic              word_end_o,
  output logic              last_o
);
  logic [BEAT_W-1:0] beat_q, beat_max;
  logic [LEN_W-1:0]  word_q;

  always_comb begin
    case (pw_i)
      PW8:     beat_max = BEAT_W'(LANES - 1);
      PW16:    beat_max = BEAT_W'(LANES / 2 - 1);
      default: beat_max = '0;
    endcase
  end

  assign word_end_o = (beat_q == beat_max);
  assign last_o     = word_end_o && (word_q == len_i);
  assign beat_o     = beat_q;
  assign word_o     = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      word_q <= '0;
    end else if (clr_i) begin
      beat_q <= '0;
      word_q <= '0;
    end else if (adv_i) begin
      if (word_end_o) begin
        beat_q <= '0;
        word_q <= word_q + 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbus_lane_map.sv
module mbus_lane_map
  import mbus_pkg::*;
(
  input  pw_e               pw_i,
  input  logic              active_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [AD_W-1:0]   wdata_i,
  output logic [LANES-1:0]  lane_no,
  output logic [AD_W-1:0]   wslice_o
);
  logic [1:0]      off;
  logic [AD_W-1:0] shifted;

  // byte offset of this beat inside the word
  always_comb begin
    case (pw_i)
      PW8:     off = beat_i[1:0];
      PW16:    off = {beat_i[0], 1'b0};
      default: off = 2'b00;
    endcase
  end

  assign shifted = wdata_i >> {off, 3'b000};

  always_comb begin
    case (pw_i)
      PW8:     wslice_o = {{(AD_W-8){1'b0}}, shifted[7:0]};
      PW16:    wslice_o = {{(AD_W-16){1'b0}}, shifted[15:0]};
      default: wslice_o = wdata_i;
    endcase
  end

  always_comb begin
    if (!active_i) begin
      lane_no = '1;
    end else begin
      case (pw_i)
        PW8:     lane_no = {2'b11, off[1], off[0]};
        PW16:    lane_no = {1'b0, 1'b1, off[1], 1'b0};
        default: lane_no = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbus_rd_pack.sv
module mbus_rd_pack
  import mbus_pkg::*;
(
  input  pw_e               pw_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [AD_W-1:0]   asm_i,
  input  logic [AD_W-1:0]   ad_i,
  output logic [AD_W-1:0]   merged_o
);
  always_comb begin
    merged_o = asm_i;
    case (pw_i)
      PW8: begin
        for (int k = 0; k < LANES; k++)
          if (BEAT_W'(k) == beat_i) merged_o[8*k +: 8] = ad_i[7:0];
      end
      PW16: begin
        for (int k = 0; k < LANES / 2; k++)
          if (1'(k) == beat_i[0]) merged_o[16*k +: 16] = ad_i[15:0];
      end
      default: merged_o = ad_i;
    endcase
  end
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             ready_o,
  input  logic [AD_W-1:0]  req_addr_i,
  input  logic             req_wr_i,
  input  logic             req_instr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [1:0]       width_i,
  input  logic [AD_W-1:0]  wr_data_i,
  output logic [LEN_W-1:0] word_idx_o,
  output logic [AD_W-1:0]  rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cfg_err_o,
  output logic [AD_W-1:0]  ad_o,
  input  logic [AD_W-1:0]  ad_i,
  output logic             cip_no,
  output logic             den_no,
  output logic             rd_no,
  output logic             wr_no,
  output logic             dtr_o,
  output logic             ide_o,
  output logic             last_no,
  output logic [LANES-1:0] lane_no,
  input  logic             ack_ni,
  input  logic             retry_ni,
  input  logic             berr_ni
);
  localparam int WA_W = AD_W - 2;

  st_e               st_q;
  pw_e               pw_q;
  logic [WA_W-1:0]   wa_q;
  logic [LEN_W-1:0]  len_q;
  logic              wr_q, instr_q, got_q;
  logic [AD_W-1:0]   asm_q, rd_data_q;
  logic              done_q, err_q, rdv_q, cfg_err_q;

  logic [BEAT_W-1:0] beat;
  logic [LEN_W-1:0]  word;
  logic              word_end, last;
  logic [AD_W-1:0]   wslice, merged;
  logic              busy, retry_ok, berr_go, retry_go, ack_go, ctr_clr;

  assign busy     = (st_q != ST_IDLE);
  // read retry only before the first accepted beat
  assign retry_ok = !retry_ni && (wr_q || !got_q);
  assign berr_go  = busy && !berr_ni;
  assign retry_go = busy && berr_ni && retry_ok;
  assign ack_go   = (st_q == ST_DATA) && berr_ni && !retry_ok && !ack_ni;
  assign ctr_clr  = !busy || retry_go || berr_go;

  mbus_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ctr_clr),
    .adv_i      (ack_go),
    .pw_i       (pw_q),
    .len_i      (len_q),
    .beat_o     (beat),
    .word_o     (word),
    .word_end_o (word_end),
    .last_o     (last)
  );

  mbus_lane_map u_lane (
    .pw_i     (pw_q),
    .active_i (busy),
    .beat_i   (beat),
    .wdata_i  (wr_data_i),
    .lane_no  (lane_no),
    .wslice_o (wslice)
  );

  mbus_rd_pack u_pack (
    .pw_i     (pw_q),
    .beat_i   (beat),
    .asm_i    (asm_q),
    .ad_i     (ad_i),
    .merged_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pw_q      <= PW32;
      wa_q      <= '0;
      len_q     <= '0;
      wr_q      <= 1'b0;
      instr_q   <= 1'b0;
      got_q     <= 1'b0;
      asm_q     <= '0;
      rd_data_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rdv_q     <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            wa_q    <= req_addr_i[AD_W-1:2];
            len_q   <= req_len_i;
            wr_q    <= req_wr_i;
            instr_q <= req_instr_i;
            got_q   <= 1'b0;
            asm_q   <= '0;
            if (pw_e'(width_i) == PWRSV) begin
              pw_q      <= PW32;
              cfg_err_q <= 1'b1;
            end else begin
              pw_q <= pw_e'(width_i);
            end
            st_q <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (berr_go) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
          end else if (!retry_go) begin
            st_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (berr_go) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
          end else if (retry_go) begin
            st_q  <= ST_ADDR;
            got_q <= 1'b0;
          end else if (ack_go) begin
            got_q <= 1'b1;
            if (!wr_q) begin
              asm_q <= merged;
              if (word_end) begin
                rd_data_q <= merged;
                rdv_q     <= 1'b1;
              end
            end
            if (last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_ADDR: ad_o = {wa_q, 2'b00};
      ST_DATA: ad_o = wr_q ? wslice : '0;
      default: ad_o = '0;
    endcase
  end

  assign ready_o    = !busy;
  assign word_idx_o = word;
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rdv_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign cfg_err_o  = cfg_err_q;
  assign cip_no     = !busy;
  assign den_no     = (st_q != ST_DATA);
  assign rd_no      = !(busy && !wr_q);
  assign wr_no      = !(busy && wr_q);
  assign dtr_o      = busy && wr_q;
  assign ide_o      = busy && instr_q;
  assign last_no    = !((st_q == ST_DATA) && last);
endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk
  import mbus_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             ready_o,
  input logic             cip_no,
  input logic             den_no,
  input logic             rd_no,
  input logic             wr_no,
  input logic             last_no,
  input logic [LANES-1:0] lane_no,
  input logic             ack_ni,
  input logic             retry_ni,
  input logic             berr_ni,
  input logic             done_o,
  input logic             err_o,
  input logic             cfg_err_o,
  input pw_e              pw_i
);
  // R7
  den_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cip_no |-> den_no);

  // R8
  last_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_no |-> !den_no);

  // R6
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cip_no |-> (rd_no != wr_no));

  // R7
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last_no && !ack_ni && berr_ni && retry_ni) |=> (cip_no && done_o));

  // R12
  berr_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cip_no && !berr_ni) |=> (cip_no && den_no && rd_no && wr_no && err_o && !done_o));

  // R5
  cfg_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  // R2
  w32_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cip_no && pw_i == PW32) |-> (lane_no == '0));

  // R3
  w16_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cip_no && pw_i == PW16) |-> (!lane_no[3] && lane_no[2] && !lane_no[0]));

  // R4
  w8_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cip_no && pw_i == PW8) |-> (lane_no[3:2] == 2'b11));

  // R13
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !req_valid_i) |=> ready_o);
endmodule

bind mbus_ctrl mbus_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .ready_o     (ready_o),
  .cip_no      (cip_no),
  .den_no      (den_no),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .last_no     (last_no),
  .lane_no     (lane_no),
  .ack_ni      (ack_ni),
  .retry_ni    (retry_ni),
  .berr_ni     (berr_ni),
  .done_o      (done_o),
  .err_o       (err_o),
  .cfg_err_o   (cfg_err_o),
  .pw_i        (pw_q)
);

// File: tb/mbus_ctrl_tb.sv
`timescale 1ns/1ps
module mbus_ctrl_tb;
  localparam int LEN_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_wr_i = 1'b0, req_instr_i = 1'b0;
  logic [31:0] req_addr_i = '0, ad_i = '0, wr_data_i;
  logic [LEN_W-1:0] req_len_i = '0, word_idx_o;
  logic [1:0] width_i = 2'b10;
  logic ready_o, rd_valid_o, done_o, err_o, cfg_err_o;
  logic [31:0] rd_data_o, ad_o;
  logic cip_no, den_no, rd_no, wr_no, dtr_o, ide_o, last_no;
  logic [3:0] lane_no;
  logic ack_ni = 1'b1, retry_ni = 1'b1, berr_ni = 1'b1;

  int n_tests = 0, n_fail = 0;
  bit finished = 0, cfg_exp = 0;
  logic [31:0] tx_seed = '0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [31:0] wgen(logic [31:0] s, logic [LEN_W-1:0] i);
    return s ^ ({28'd0, i} * 32'h9E37_79B9) ^ 32'h0102_0408;
  endfunction
  function automatic logic [31:0] rgen(logic [31:0] s, int i);
    return ~s ^ (i * 32'h85EB_CA6B) ^ 32'h5A00_00A5;
  endfunction
  function automatic logic [3:0] exp_lanes(int eff, int off);
    logic [1:0] o = off[1:0];
    case (eff)
      0: return {2'b11, o[1], o[0]};
      1: return {1'b0, 1'b1, o[1], 1'b0};
      default: return 4'h0;
    endcase
  endfunction
  function automatic logic [31:0] slice(int eff, logic [31:0] w, int b);
    case (eff)
      0: return (w >> (8 * b)) & 32'hFF;
      1: return (w >> (16 * b)) & 32'hFFFF;
      default: return w;
    endcase
  endfunction

  assign wr_data_i = wgen(tx_seed, word_idx_o);

  mbus_ctrl #(.LEN_W(LEN_W)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one transfer; retry_at/berr_at are global beat indices (-1 none).
  task automatic run_tx(input logic [31:0] addr, input int len, input bit wr, input bit instr,
                        input logic [1:0] wcode, input int retry_at, input int berr_at,
                        input bit poke, input bit waits);
    int eff, bpw, total, g, w, b, off;
    bit got, rt_pend, restart;
    tx_seed = $urandom;
    eff = (wcode == 2'b11) ? 2 : int'(wcode);
    bpw = (eff == 0) ? 4 : (eff == 1) ? 2 : 1;
    total = (len + 1) * bpw;
    if (wcode == 2'b11) cfg_exp = 1;
    check("R13 ready before request", {31'd0, ready_o}, 32'd1);
    req_addr_i = addr; req_wr_i = wr; req_instr_i = instr;
    req_len_i = LEN_W'(len); width_i = wcode; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rt_pend = (retry_at >= 0);
    restart = 1;
    while (restart) begin
      restart = 0;
      // address phase
      check("R6 cip in address", {31'd0, cip_no}, 32'd0);
      check("R6 den in address", {31'd0, den_no}, 32'd1);
      check("R6 address on bus", ad_o, {addr[31:2], 2'b00});
      check("R6 dtr", {31'd0, dtr_o}, {31'd0, wr});
      check("R6 rd strobe", {31'd0, rd_no}, {31'd0, wr});
      check("R6 wr strobe", {31'd0, wr_no}, {31'd0, !wr});
      check("R6 ide", {31'd0, ide_o}, {31'd0, instr});
      check("R2 R3 R4 lanes in address", {28'd0, lane_no}, {28'd0, exp_lanes(eff, 0)});
      @(negedge clk_i);
      g = 0; got = 0;
      while (g < total && !restart) begin
        w = g / bpw; b = g % bpw;
        off = (eff == 0) ? b : (eff == 1) ? 2 * b : 0;
        check("R7 den in beat", {31'd0, den_no}, 32'd0);
        check("R7 cip in beat", {31'd0, cip_no}, 32'd0);
        check("R8 last flag", {31'd0, last_no}, {31'd0, !(g == total - 1)});
        check("R1 R2 R3 R4 beat lanes", {28'd0, lane_no}, {28'd0, exp_lanes(eff, off)});
        check("R9 word index", {28'd0, word_idx_o}, w);
        if (wr) check("R9 write slice", ad_o, slice(eff, wgen(tx_seed, LEN_W'(w)), b));
        if (poke && g == 0) begin
          check("R13 busy not ready", {31'd0, ready_o}, 32'd0);
          req_valid_i = 1'b1; req_addr_i = 32'hDEAD_BEE0;
        end
        if (waits && ($urandom % 4 == 0)) begin
          // wait state; on a read after data a lone retry must be ignored (R10)
          ad_i = $urandom;
          if (!wr && got) retry_ni = 1'b0;
          @(negedge clk_i);
          retry_ni = 1'b1; req_valid_i = 1'b0;
          continue;
        end
        ad_i = ($urandom & ((eff == 0) ? 32'hFFFF_FF00 : (eff == 1) ? 32'hFFFF_0000 : 32'h0))
               | slice(eff, rgen(tx_seed, w), b);
        ack_ni = 1'b0;
        if (g == berr_at) begin
          berr_ni = 1'b0;
          @(negedge clk_i);
          ack_ni = 1'b1; berr_ni = 1'b1; req_valid_i = 1'b0;
          check("R12 cycle ended", {31'd0, cip_no}, 32'd1);
          check("R12 strobes released", {29'd0, den_no, rd_no, wr_no}, 32'd7);
          check("R12 err pulse", {31'd0, err_o}, 32'd1);
          check("R12 no done", {31'd0, done_o}, 32'd0);
          @(negedge clk_i);
          return;
        end
        if (g == retry_at && rt_pend) begin
          retry_ni = 1'b0;
          rt_pend = 0;
          @(negedge clk_i);
          ack_ni = 1'b1; retry_ni = 1'b1; req_valid_i = 1'b0;
          if (wr || !got) begin
            check(wr ? "R11 write retry restarts" : "R10 read retry restarts",
                  {31'd0, den_no}, 32'd1);
            restart = 1;
            continue;
          end
        end else begin
          @(negedge clk_i);
          ack_ni = 1'b1; req_valid_i = 1'b0;
        end
        got = 1; g++;
        if (!wr && b == bpw - 1) begin
          check("R9 rd_valid", {31'd0, rd_valid_o}, 32'd1);
          check("R9 rd_data", rd_data_o, rgen(tx_seed, w));
        end
      end
    end
    check("R7 cycle ended", {31'd0, cip_no}, 32'd1);
    check("R7 strobes released", {28'd0, den_no, rd_no, wr_no, last_no}, 32'hF);
    check("R7 done pulse", {31'd0, done_o}, 32'd1);
    check("R4 idle lanes", {28'd0, lane_no}, 32'hF);
    check("R5 cfg_err", {31'd0, cfg_err_o}, {31'd0, cfg_exp});
    @(negedge clk_i);
    check("R13 stays idle", {30'd0, cip_no, done_o}, 32'd2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R7 reset strobes", {26'd0, cip_no, den_no, rd_no, wr_no, last_no, ready_o}, 32'h3F);
    check("R4 reset lanes", {28'd0, lane_no}, 32'hF);
    check("R5 reset cfg_err", {29'd0, cfg_err_o, done_o, err_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_tx(32'h1000_0004, 0, 1, 0, 2'b10, -1, -1, 0, 0);  // R2 single write
    run_tx(32'h2000_0010, 1, 0, 1, 2'b01, -1, -1, 0, 0);  // R3 16-bit read
    run_tx(32'h3000_0023, 2, 1, 0, 2'b00, -1, -1, 1, 0);  // R4 R13 8-bit write, busy poke
    run_tx(32'h4000_0000, 1, 0, 0, 2'b00, 0, -1, 0, 0);   // R10 retry before data
    run_tx(32'h4100_0000, 1, 0, 0, 2'b01, 2, -1, 0, 0);   // R10 retry with ack ignored
    run_tx(32'h5000_0008, 1, 1, 0, 2'b01, 3, -1, 0, 0);   // R11 write retry mid
    run_tx(32'h6000_0000, 1, 1, 0, 2'b00, -1, 1, 0, 0);   // R12 berr with ack
    run_tx(32'h6100_0000, 0, 0, 0, 2'b10, -1, 0, 0, 0);   // R12 read berr
    run_tx(32'h7000_0000, 1, 0, 1, 2'b11, -1, -1, 0, 0);  // R5 reserved width
    for (int i = 0; i < 40; i++) begin
      int len_r = $urandom % 4;
      int tot = (len_r + 1) * 4;
      int rsel = $urandom % 6;
      int bsel = $urandom % 8;
      logic [1:0] wc = 2'($urandom % 4);
      run_tx($urandom, len_r, 1'($urandom), 1'($urandom), wc,
             (rsel == 0) ? int'($urandom % tot) : -1,
             (bsel == 0) ? int'($urandom % tot) : -1, 0, 1);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule